// File: doc/BRIEF.md
# Shadow Register Bridge with Keyed Write Lock

This block is the bus-facing register front end of a peripheral whose real state lives in a slow, free-running clock domain (nominally 32 kHz). Software writes land at once in bus-clock shadow registers. Dirty shadows are then carried as a batch into the slow domain through a toggle request. The toggle crosses through a multi-flop synchroniser, and an acknowledge toggle returns the same way. A pending field tells software whether any written value is still in flight. A reload command runs the opposite path. It snapshots the slow-domain registers and the event status, and copies them back into the shadows.

Nothing can be written until a two-word key sequence has been presented to two kick registers. The event status bit is write-one-to-clear. The interrupt output is driven from the slow domain, so a clear only releases it on the slow edge that applies the transfer, never when the bus write arrives. Logic behind the block may update its own slow-domain registers through a load port. Only the registers that software actually touched are overwritten by a transfer.

Top module: `shadow_sync_bridge`

## Requirements
- R1: Writing 0x83E70B13 to byte address 0x1C and then 0x95A4F1E0 to 0x20 opens the lock. From the next cycle, bit 1 of the control register at 0x14 reads 1.
- R2: Before the lock opens, any other value written to either key address sends the sequence back to its start. A second key alone, or a second key following a wrong first key, leaves bit 1 of 0x14 at 0.
- R3: While locked, writes to data, status, control and sync registers are ignored. Their readback stays at its previous value.
- R4: Once open, the lock stays open until reset, whatever is then written to the key addresses.
- R5: A data write to byte address 4*i (i below NUM_DATA) reads back in the next cycle. Bit 0 of the sync register at 0x18 reads 1 from then until the value has been applied in the slow domain. After that, the slow-state output holds the value.
- R6: Bit 0 of 0x14 enables transfers (reset 0). While it is 0, writes stay pending and the slow state is unchanged. Setting it lets them complete.
- R7: A transfer finishes within four slow-clock periods plus eight bus cycles of the write.
- R8: A transfer overwrites only the registers written since the previous transfer. Values loaded by slow-side logic into other registers are kept.
- R9: A slow-side event sets the status bit (bit 0 of 0x10) in the slow domain and drives irqOut high. Writing 1 to bit 0 of 0x10 clears the shadow bit at once. irqOut stays high until the slow edge that applies the clear, and is low once bit 0 of 0x18 reads 0.
- R10: Writing 1 to bit 31 of 0x18 requests a reload. Bit 1 of 0x18 reads 1 until the slow-domain registers and status have been copied into the shadows. A reload waits for pending writes to complete, and never overwrites a shadow that is still dirty.
- R11: After reset, every readable register reads 0, the lock is closed, irqOut is low and the slow state is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| slowClk | input | 1 | Slow domain clock, asynchronous to clk |
| rstN | input | 1 | Active-low asynchronous reset for both domains |
| busWe | input | 1 | Write strobe, one bus cycle per write |
| busAddr | input | ADDR_W | Byte address of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| slowEvent | input | 1 | Slow-domain event that sets the status bit |
| slowLoadEn | input | 1 | Slow-side logic loads one slow register |
| slowLoadIdx | input | IDX_W | Index of the slow register to load |
| slowLoadData | input | 32 | Value for the slow-side load |
| slowState | output | NUM_DATA*32 | Slow-domain copies of the data registers, register i at bits 32*i upward |
| irqOut | output | 1 | Slow-domain event status |

## Verification
Suppose the lock state machine is wrong. Then a write that should be ignored becomes visible in the readback of the next bus cycle, or the unlock bit fails to rise the cycle after the second key. A broken transfer handshake shows as a pending bit that never clears within the R7 window, or that clears while slowState still shows the old value. A wrong dirty mask shows as slowState losing a slow-side loaded value after an unrelated write. A status clear that releases too early shows irqOut falling within a few bus cycles of the clear write, well before the earliest slow edge that may legally apply it.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  localparam int DATA_W      = 32;
  localparam int ADDR_STATUS = 'h10;
  localparam int ADDR_CTRL   = 'h14;
  localparam int ADDR_SYNC   = 'h18;
  localparam int ADDR_KEYA   = 'h1C;
  localparam int ADDR_KEYB   = 'h20;

  typedef enum logic [1:0] {
    LK_SHUT = 2'd0,
    LK_HALF = 2'd1,
    LK_OPEN = 2'd2
  } lockState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic wrShadow;   // gated bus write, datapath decodes address
    logic capture;    // copy dirty shadows into the hold stage
    logic loadBack;   // copy slow snapshot into clean shadows
  } strobe_t;
endpackage

// File: rtl/ssb_tsync.sv
module ssb_tsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], d};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= d;
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ssb_ctrl.sv
module ssb_ctrl
  import ssb_pkg::*;
#(
  parameter int          ADDR_W      = 6,
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] KEY_A       = 32'h83E70B13,
  parameter logic [31:0] KEY_B       = 32'h95A4F1E0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  logic              anyDirty,
  input  logic              xferAckTgl,
  input  logic              rldAckTgl,
  output strobe_t           strb,
  output logic              unlocked,
  output logic              syncEn,
  output logic [1:0]        pend,
  output logic              xferBusy,
  output logic              rldBusy,
  output logic              reqTgl,
  output logic              rldTgl
);
  lockState_t lockSt;
  logic       rldReq;
  logic       xferAckSync, rldAckSync;
  logic       startXfer, startRld, xferDone, rldDone;
  logic       hitKeyA, hitKeyB, hitCtrl, hitSync;

  ssb_tsync #(.STAGES(SYNC_STAGES)) u_ackSync (
    .clk(clk), .rstN(rstN), .d(xferAckTgl), .q(xferAckSync));
  ssb_tsync #(.STAGES(SYNC_STAGES)) u_rldSync (
    .clk(clk), .rstN(rstN), .d(rldAckTgl), .q(rldAckSync));

  assign hitKeyA  = busAddr == ADDR_W'(ADDR_KEYA);
  assign hitKeyB  = busAddr == ADDR_W'(ADDR_KEYB);
  assign hitCtrl  = busAddr == ADDR_W'(ADDR_CTRL);
  assign hitSync  = busAddr == ADDR_W'(ADDR_SYNC);
  assign unlocked = lockSt == LK_OPEN;

  // lock sequence: wrong key anywhere restarts it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockSt <= LK_SHUT;
    end else if (busWe && !unlocked) begin
      if (hitKeyA)
        lockSt <= (busWdata == KEY_A) ? LK_HALF : LK_SHUT;
      else if (hitKeyB)
        lockSt <= (lockSt == LK_HALF && busWdata == KEY_B) ? LK_OPEN : LK_SHUT;
    end
  end

  assign xferDone  = xferBusy && (xferAckSync == reqTgl);
  assign rldDone   = rldBusy && (rldAckSync == rldTgl);
  assign startXfer = syncEn && anyDirty && !xferBusy && !rldBusy;
  assign startRld  = syncEn && rldReq && !anyDirty && !xferBusy && !rldBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncEn   <= 1'b0;
      rldReq   <= 1'b0;
      xferBusy <= 1'b0;
      rldBusy  <= 1'b0;
      reqTgl   <= 1'b0;
      rldTgl   <= 1'b0;
    end else begin
      if (busWe && unlocked && hitCtrl) syncEn <= busWdata[0];
      if (startRld) rldReq <= 1'b0;
      else if (busWe && unlocked && hitSync && busWdata[31]) rldReq <= 1'b1;
      if (startXfer) begin
        xferBusy <= 1'b1;
        reqTgl   <= ~reqTgl;
      end else if (xferDone) begin
        xferBusy <= 1'b0;
      end
      if (startRld) begin
        rldBusy <= 1'b1;
        rldTgl  <= ~rldTgl;
      end else if (rldDone) begin
        rldBusy <= 1'b0;
      end
    end
  end

  always_comb begin
    strb          = '0;
    strb.wrShadow = busWe && unlocked;
    strb.capture  = startXfer;
    strb.loadBack = rldDone;
  end

  assign pend = {rldReq | rldBusy, anyDirty | xferBusy};
endmodule

// File: rtl/ssb_datapath.sv
module ssb_datapath
  import ssb_pkg::*;
#(
  parameter int NUM_DATA = 4,
  parameter int ADDR_W   = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                strb,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic [31:0]            busWdata,
  input  logic [NUM_DATA*32-1:0] snapData,
  input  logic                   snapStatus,
  input  logic                   unlocked,
  input  logic                   syncEn,
  input  logic [1:0]             pend,
  output logic [31:0]            busRdata,
  output logic                   anyDirty,
  output logic [NUM_DATA*32-1:0] holdData,
  output logic [NUM_DATA:0]      holdMask
);
  localparam int STAT_BIT = NUM_DATA;

  logic [31:0]     shadow [NUM_DATA];
  logic            shStatus;
  logic [NUM_DATA:0] dirty, newMask;
  logic [NUM_DATA-1:0] hitData;
  logic            hitStatus;

  generate
    for (genvar i = 0; i < NUM_DATA; i++) begin : g_hit
      assign hitData[i] = busAddr == ADDR_W'(4 * i);
    end
  endgenerate
  assign hitStatus = busAddr == ADDR_W'(ADDR_STATUS);

  always_comb begin
    newMask = '0;
    if (strb.wrShadow) begin
      newMask[NUM_DATA-1:0] = hitData;
      newMask[STAT_BIT]     = hitStatus && busWdata[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_DATA; i++) shadow[i] <= '0;
      shStatus <= 1'b0;
      dirty    <= '0;
      holdData <= '0;
      holdMask <= '0;
    end else begin
      for (int i = 0; i < NUM_DATA; i++) begin
        if (newMask[i])
          shadow[i] <= busWdata;
        else if (strb.loadBack && !dirty[i])
          shadow[i] <= snapData[i*32 +: 32];
      end
      if (newMask[STAT_BIT])
        shStatus <= 1'b0;
      else if (strb.loadBack && !dirty[STAT_BIT])
        shStatus <= snapStatus;
      dirty <= (strb.capture ? '0 : dirty) | newMask;
      if (strb.capture) begin
        for (int i = 0; i < NUM_DATA; i++) holdData[i*32 +: 32] <= shadow[i];
        holdMask <= dirty;
      end
    end
  end

  assign anyDirty = |dirty;

  always_comb begin
    busRdata = '0;
    for (int i = 0; i < NUM_DATA; i++)
      if (hitData[i]) busRdata = shadow[i];
    if (hitStatus) busRdata = {31'd0, shStatus};
    if (busAddr == ADDR_W'(ADDR_CTRL)) busRdata = {30'd0, unlocked, syncEn};
    if (busAddr == ADDR_W'(ADDR_SYNC)) busRdata = {30'd0, pend};
  end
endmodule

// File: rtl/ssb_slow.sv
module ssb_slow #(
  parameter int NUM_DATA    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int IDX_W       = 2
) (
  input  logic                   slowClk,
  input  logic                   rstN,
  input  logic                   reqTgl,
  input  logic                   rldTgl,
  input  logic [NUM_DATA*32-1:0] holdData,
  input  logic [NUM_DATA:0]      holdMask,
  input  logic                   slowEvent,
  input  logic                   slowLoadEn,
  input  logic [IDX_W-1:0]       slowLoadIdx,
  input  logic [31:0]            slowLoadData,
  output logic                   xferAckTgl,
  output logic                   rldAckTgl,
  output logic                   slowApply,
  output logic [NUM_DATA*32-1:0] snapData,
  output logic                   snapStatus,
  output logic [NUM_DATA*32-1:0] slowState,
  output logic                   irqOut
);
  logic [31:0] slowReg [NUM_DATA];
  logic        slowStat;
  logic        reqSync, rldSync, doSnap;

  ssb_tsync #(.STAGES(SYNC_STAGES)) u_reqSync (
    .clk(slowClk), .rstN(rstN), .d(reqTgl), .q(reqSync));
  ssb_tsync #(.STAGES(SYNC_STAGES)) u_rldSync (
    .clk(slowClk), .rstN(rstN), .d(rldTgl), .q(rldSync));

  assign slowApply = reqSync != xferAckTgl;
  assign doSnap    = rldSync != rldAckTgl;

  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_DATA; i++) slowReg[i] <= '0;
      slowStat   <= 1'b0;
      xferAckTgl <= 1'b0;
      rldAckTgl  <= 1'b0;
      snapData   <= '0;
      snapStatus <= 1'b0;
    end else begin
      // bus transfer has priority over a slow-side load of the same register
      for (int i = 0; i < NUM_DATA; i++) begin
        if (slowApply && holdMask[i])
          slowReg[i] <= holdData[i*32 +: 32];
        else if (slowLoadEn && slowLoadIdx == IDX_W'(i))
          slowReg[i] <= slowLoadData;
      end
      // a new event beats a clear on the same edge
      if (slowEvent)
        slowStat <= 1'b1;
      else if (slowApply && holdMask[NUM_DATA])
        slowStat <= 1'b0;
      if (slowApply) xferAckTgl <= reqSync;
      if (doSnap) begin
        for (int i = 0; i < NUM_DATA; i++) snapData[i*32 +: 32] <= slowReg[i];
        snapStatus <= slowStat;
        rldAckTgl  <= rldSync;
      end
    end
  end

  generate
    for (genvar i = 0; i < NUM_DATA; i++) begin : g_out
      assign slowState[i*32 +: 32] = slowReg[i];
    end
  endgenerate
  assign irqOut = slowStat;
endmodule

// File: rtl/shadow_sync_bridge.sv
module shadow_sync_bridge
  import ssb_pkg::*;
#(
  parameter int          NUM_DATA    = 4,
  parameter int          ADDR_W      = 6,
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] KEY_A       = 32'h83E70B13,
  parameter logic [31:0] KEY_B       = 32'h95A4F1E0,
  localparam int         IDX_W       = (NUM_DATA > 1) ? $clog2(NUM_DATA) : 1
) (
  input  logic                   clk,
  input  logic                   slowClk,
  input  logic                   rstN,
  input  logic                   busWe,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic [31:0]            busWdata,
  output logic [31:0]            busRdata,
  input  logic                   slowEvent,
  input  logic                   slowLoadEn,
  input  logic [IDX_W-1:0]       slowLoadIdx,
  input  logic [31:0]            slowLoadData,
  output logic [NUM_DATA*32-1:0] slowState,
  output logic                   irqOut
);
  strobe_t               strb;
  logic                  unlocked, syncEn, anyDirty;
  logic [1:0]            pend;
  logic                  xferBusy, rldBusy, reqTgl, rldTgl;
  logic                  xferAckTgl, rldAckTgl, slowApply, snapStatus;
  logic [NUM_DATA*32-1:0] holdData, snapData;
  logic [NUM_DATA:0]     holdMask;

  ssb_ctrl #(
    .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES), .KEY_A(KEY_A), .KEY_B(KEY_B)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .anyDirty(anyDirty), .xferAckTgl(xferAckTgl), .rldAckTgl(rldAckTgl),
    .strb(strb), .unlocked(unlocked), .syncEn(syncEn), .pend(pend),
    .xferBusy(xferBusy), .rldBusy(rldBusy), .reqTgl(reqTgl), .rldTgl(rldTgl));

  ssb_datapath #(.NUM_DATA(NUM_DATA), .ADDR_W(ADDR_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .busAddr(busAddr), .busWdata(busWdata),
    .snapData(snapData), .snapStatus(snapStatus), .unlocked(unlocked),
    .syncEn(syncEn), .pend(pend), .busRdata(busRdata), .anyDirty(anyDirty),
    .holdData(holdData), .holdMask(holdMask));

  ssb_slow #(.NUM_DATA(NUM_DATA), .SYNC_STAGES(SYNC_STAGES), .IDX_W(IDX_W)) u_slow (
    .slowClk(slowClk), .rstN(rstN), .reqTgl(reqTgl), .rldTgl(rldTgl),
    .holdData(holdData), .holdMask(holdMask), .slowEvent(slowEvent),
    .slowLoadEn(slowLoadEn), .slowLoadIdx(slowLoadIdx), .slowLoadData(slowLoadData),
    .xferAckTgl(xferAckTgl), .rldAckTgl(rldAckTgl), .slowApply(slowApply),
    .snapData(snapData), .snapStatus(snapStatus), .slowState(slowState),
    .irqOut(irqOut));
endmodule

// File: rtl/ssb_checker.sv
module ssb_checker
  import ssb_pkg::*;
#(
  parameter int          NUM_DATA = 4,
  parameter int          ADDR_W   = 6,
  parameter logic [31:0] KEY_B    = 32'h95A4F1E0
) (
  input logic                   clk,
  input logic                   slowClk,
  input logic                   rstN,
  input logic                   busWe,
  input logic [ADDR_W-1:0]      busAddr,
  input logic [31:0]            busWdata,
  input logic                   unlocked,
  input logic                   anyDirty,
  input logic                   xferBusy,
  input logic                   rldBusy,
  input logic [NUM_DATA*32-1:0] holdData,
  input logic                   slowApply,
  input logic                   irqOut
);
  a_r1_open_after_second_key: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unlocked) |-> $past(busWe && busAddr == ADDR_W'(ADDR_KEYB) && busWdata == KEY_B));

  a_r4_lock_stays_open: assert property (@(posedge clk) disable iff (!rstN)
    unlocked |=> unlocked);

  a_r3_nothing_dirty_while_locked: assert property (@(posedge clk) disable iff (!rstN)
    !unlocked |-> !anyDirty);

  a_r5_hold_stable_in_flight: assert property (@(posedge clk) disable iff (!rstN)
    (xferBusy && $past(xferBusy)) |-> $stable(holdData));

  a_r10_channels_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(xferBusy && rldBusy));

  a_r9_irq_falls_on_apply: assert property (@(posedge slowClk) disable iff (!rstN)
    $fell(irqOut) |-> $past(slowApply));
endmodule

bind shadow_sync_bridge ssb_checker #(
  .NUM_DATA(NUM_DATA), .ADDR_W(ADDR_W), .KEY_B(KEY_B)
) u_chk (
  .clk(clk), .slowClk(slowClk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
  .busWdata(busWdata), .unlocked(unlocked), .anyDirty(anyDirty),
  .xferBusy(xferBusy), .rldBusy(rldBusy), .holdData(holdData),
  .slowApply(slowApply), .irqOut(irqOut));

// File: tb/sim_shadow_sync_bridge.sv
module sim_shadow_sync_bridge;
  localparam int CLK_PERIOD  = 10;
  localparam int SLOW_PERIOD = 170;
  localparam int NUM_DATA    = 4;
  localparam int R7_BOUND    = 4 * SLOW_PERIOD / CLK_PERIOD + 8;
  localparam logic [5:0] A_STAT = 6'h10, A_CTRL = 6'h14, A_SYNC = 6'h18,
                         A_KEYA = 6'h1C, A_KEYB = 6'h20;
  localparam logic [31:0] KA = 32'h83E70B13, KB = 32'h95A4F1E0;

  logic clk = 0, slowClk = 0, rstN = 0;
  logic busWe = 0;
  logic [5:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic slowEvent = 0, slowLoadEn = 0;
  logic [1:0] slowLoadIdx = '0;
  logic [31:0] slowLoadData = '0;
  logic [NUM_DATA*32-1:0] slowState;
  logic irqOut;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(SLOW_PERIOD/2) slowClk = ~slowClk;

  shadow_sync_bridge #(.NUM_DATA(NUM_DATA)) u0 (
    .clk(clk), .slowClk(slowClk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .slowEvent(slowEvent),
    .slowLoadEn(slowLoadEn), .slowLoadIdx(slowLoadIdx), .slowLoadData(slowLoadData),
    .slowState(slowState), .irqOut(irqOut));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic waitIdle(input logic [31:0] mask, output int cyc);
    logic [31:0] d;
    cyc = 0;
    rd(A_SYNC, d);
    while ((d & mask) != 0 && cyc < 5000) begin
      cyc++;
      rd(A_SYNC, d);
    end
  endtask

  function automatic logic [31:0] slotOf(input int i);
    return slowState[i*32 +: 32];
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    rd(6'h00, d); chk("R11 data0", d, 0);
    rd(A_STAT, d); chk("R11 status", d, 0);
    rd(A_CTRL, d); chk("R11 ctrl", d, 0);
    rd(A_SYNC, d); chk("R11 sync", d, 0);
    chk("R11 irqOut", {31'd0, irqOut}, 0);
    chk("R11 slowState", slotOf(0) | slotOf(1) | slotOf(2) | slotOf(3), 0);
  endtask

  task automatic t_locked;
    logic [31:0] d;
    wr(6'h00, 32'h1234); wr(A_CTRL, 1); wr(A_SYNC, 32'h8000_0000);
    rd(6'h00, d); chk("R3 data0 ignored", d, 0);
    rd(A_CTRL, d); chk("R3 ctrl ignored", d, 0);
    rd(A_SYNC, d); chk("R3 sync ignored", d, 0);
  endtask

  task automatic t_badKeys;
    logic [31:0] d;
    wr(A_KEYB, KB);
    rd(A_CTRL, d); chk("R2 second key alone", d[1], 0);
    wr(A_KEYA, 32'h1); wr(A_KEYB, KB);
    rd(A_CTRL, d); chk("R2 wrong first key", d[1], 0);
    wr(A_KEYA, KA); wr(A_KEYA, 32'h5); wr(A_KEYB, KB);
    rd(A_CTRL, d); chk("R2 first key revoked", d[1], 0);
    wr(A_KEYA, KA); wr(A_KEYB, 32'h7);
    rd(A_CTRL, d); chk("R2 wrong second key", d[1], 0);
  endtask

  task automatic t_unlock;
    logic [31:0] d;
    wr(A_KEYA, KA); wr(A_KEYB, KB);
    rd(A_CTRL, d); chk("R1 unlocked", d[1], 1);
    wr(A_KEYA, 32'h0); wr(A_KEYB, 32'h0);
    rd(A_CTRL, d); chk("R4 stays open", d[1], 1);
  endtask

  task automatic t_syncOff;
    logic [31:0] d;
    int cyc;
    wr(6'h04, 32'hA5A5);
    rd(6'h04, d); chk("R5 shadow readback", d, 32'hA5A5);
    repeat (6 * SLOW_PERIOD / CLK_PERIOD) @(negedge clk);
    rd(A_SYNC, d); chk("R6 held pending", d[0], 1);
    chk("R6 slow unchanged", slotOf(1), 0);
    wr(A_CTRL, 1);
    waitIdle(1, cyc);
    chk("R6 completes after enable", (cyc <= R7_BOUND) ? 1 : 0, 1);
    chk("R6 slow value", slotOf(1), 32'hA5A5);
  endtask

  task automatic t_transfer;
    logic [31:0] d;
    int cyc;
    wr(6'h08, 32'hDEADBEEF);
    rd(A_SYNC, d); chk("R5 pending set", d[0], 1);
    waitIdle(1, cyc);
    chk("R7 within bound", (cyc + 1 <= R7_BOUND) ? 1 : 0, 1);
    chk("R5 slow value", slotOf(2), 32'hDEADBEEF);
  endtask

  task automatic t_mask;
    int cyc;
    @(negedge slowClk);
    slowLoadEn = 1; slowLoadIdx = 2'd3; slowLoadData = 32'h77;
    @(negedge slowClk);
    slowLoadEn = 0;
    chk("R8 slow load", slotOf(3), 32'h77);
    wr(6'h00, 32'h11);
    waitIdle(1, cyc);
    chk("R8 written reg", slotOf(0), 32'h11);
    chk("R8 untouched reg kept", slotOf(3), 32'h77);
  endtask

  task automatic t_reload;
    logic [31:0] d;
    int cyc;
    wr(A_SYNC, 32'h8000_0000);
    rd(A_SYNC, d); chk("R10 reload pending", d[1], 1);
    waitIdle(2, cyc);
    rd(6'h0C, d); chk("R10 reloaded value", d, 32'h77);
    rd(6'h00, d); chk("R10 other shadow", d, 32'h11);
    wr(6'h04, 32'h5);
    wr(A_SYNC, 32'h8000_0000);
    waitIdle(3, cyc);
    rd(6'h04, d); chk("R10 dirty shadow kept", d, 32'h5);
    chk("R10 write landed first", slotOf(1), 32'h5);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    int cyc;
    @(negedge slowClk); slowEvent = 1;
    @(negedge slowClk); slowEvent = 0;
    chk("R9 irq set", {31'd0, irqOut}, 1);
    wr(A_SYNC, 32'h8000_0000);
    waitIdle(2, cyc);
    rd(A_STAT, d); chk("R9 status reloaded", d, 1);
    @(posedge slowClk);
    wr(A_STAT, 1);
    rd(A_STAT, d); chk("R9 shadow cleared", d, 0);
    repeat (8) @(negedge clk);
    chk("R9 irq held before slow edge", {31'd0, irqOut}, 1);
    waitIdle(1, cyc);
    chk("R9 irq released", {31'd0, irqOut}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_locked();
    t_badKeys();
    t_unlock();
    t_syncOff();
    t_transfer();
    t_mask();
    t_reload();
    t_irq();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule